// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two per-CPU pending vectors for a small multiprocessor: one for inter-processor interrupts (IPIs) and one for the periodic timer. Each pending bit drives one interrupt line directly. IPI lines are the level-3 interrupts and timer lines are the level-2 interrupts of the CPU they belong to. Software uses a 64-bit register port to post and retire interrupts. A combined control register can request IPIs, retire IPIs and retire timer interrupts in a single write. Three dedicated registers cover the same operations one at a time. A one-cycle `tick` input marks every active CPU as having a timer interrupt.

The number of CPUs that actually exist is the parameter `N_ACTIVE` (1 to 4). The block always has four CPU slots. Mask bits for slots at or above `N_ACTIVE` have no effect. Redundant operations are still carried out, but they raise a one-cycle warning pulse. Malformed writes are dropped and raise a one-cycle error pulse.

Top module: `ipi_timer_intc`

## Requirements
- R1: While reset is asserted, and after it is released, both pending vectors are zero, all interrupt lines are low, and `warn_pulse` and `err_pulse` are low.
- R2: A write to the control register (`req_sel`=0) with mask bits in wdata[15:12] sets IPI-pending for those active CPUs. Bit 12 is CPU 0. The matching `ipi_irq` lines go high after the clock edge that takes the write.
- R3: In a control-register write, wdata[11:8] retires pending IPIs and wdata[7:4] retires pending timer interrupts, one bit per CPU with bit 8 and bit 4 as CPU 0. All three fields act in the same write.
- R4: When one write both requests and retires an IPI for the same CPU, the request is applied first and the retire second. The net result is not pending, and no warning is raised for that CPU.
- R5: `warn_pulse` is high for the one cycle after a write that requests an IPI already pending, or that retires an IPI that is not pending once the same write's requests are applied. The pending state still follows R2–R4.
- R6: A control-register write whose wdata[15:4] is zero raises `err_pulse` for one cycle and changes nothing, unless wdata[28] is set. A write with only wdata[28] set is accepted silently and changes nothing.
- R7: A `tick` sets timer-pending for every active CPU without raising a warning. If a timer retire comes in the same cycle as a tick, the tick wins and the bit stays set.
- R8: A control-register read returns IPI-pending in bits 11:8, timer-pending in bits 7:4 and `req_cpu` in bits 1:0, with every other bit zero. The data is on `rd_data` in the same cycle as the request.
- R9: Register select 1 reads IPI-pending in bits 3:0, and a write to it retires the IPIs named in wdata[3:0]. Select 2 does the same for timer-pending. Select 3 sets IPI-pending from wdata[3:0] and reads as zero. Reads change no state.
- R10: A write to select 1, 2 or 3 with wdata[3:0] zero raises `err_pulse` for one cycle and changes nothing.
- R11: Mask bits for CPUs at or above `N_ACTIVE` are ignored. Those CPUs' lines stay low, and those bits raise no warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle timer event for all active CPUs |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 control, 1 IPI-pending, 2 timer-pending, 3 IPI request |
| req_cpu | input | 2 | Number of the CPU making the access |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, same cycle, zero when no read is requested |
| ipi_irq | output | 4 | Level-3 IPI line per CPU |
| tmr_irq | output | 4 | Level-2 timer line per CPU |
| warn_pulse | output | 1 | Redundant post or retire seen on the previous cycle's write |
| err_pulse | output | 1 | Malformed write seen on the previous cycle |

## Verification
A write or tick changes the interrupt lines and the warning and error pulses exactly one clock edge later, because each is a single register stage. Read data is combinational and is due in the same cycle as the request. The bench drives every stimulus on a falling edge and lets one rising edge pass. It then samples the lines and pulses on the following falling edge, before the next rising edge can clear the pulses. Reads are sampled one time unit after being driven, within the same low phase. The main sweep covers every combination of starting IPI state, request field and retire field on a three-CPU configuration.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CPU_SLOTS = 4;
  localparam int DATA_W    = 64;

  localparam int REQ_LSB   = 12;
  localparam int IPICLR_LSB = 8;
  localparam int TMRCLR_LSB = 4;
  localparam int ACCEPT_BIT = 28;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_IPI_PEND = 2'd1,
    SEL_TMR_PEND = 2'd2,
    SEL_IPI_REQ  = 2'd3
  } reg_sel_e;

  typedef logic [CPU_SLOTS-1:0] cpu_mask_t;
endpackage

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode
  import intc_pkg::*;
#(
  parameter int N_ACTIVE = 4
) (
  input  logic              valid,
  input  logic              write,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output cpu_mask_t         ipi_set,
  output cpu_mask_t         ipi_clr,
  output cpu_mask_t         tmr_clr,
  output logic              err
);
  localparam cpu_mask_t ACT = cpu_mask_t'((1 << N_ACTIVE) - 1);

  cpu_mask_t f_req, f_iclr, f_tclr, f_low;
  logic      unused_wdata;

  assign f_req  = wdata[REQ_LSB    +: CPU_SLOTS];
  assign f_iclr = wdata[IPICLR_LSB +: CPU_SLOTS];
  assign f_tclr = wdata[TMRCLR_LSB +: CPU_SLOTS];
  assign f_low  = wdata[0 +: CPU_SLOTS];
  assign unused_wdata = ^{wdata[DATA_W-1:ACCEPT_BIT+1], wdata[ACCEPT_BIT-1:REQ_LSB+CPU_SLOTS]};

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    err     = 1'b0;
    if (valid && write) begin
      unique case (sel)
        SEL_CTRL: begin
          if (f_req == '0 && f_iclr == '0 && f_tclr == '0) begin
            err = !wdata[ACCEPT_BIT];
          end else begin
            ipi_set = f_req  & ACT;
            ipi_clr = f_iclr & ACT;
            tmr_clr = f_tclr & ACT;
          end
        end
        SEL_IPI_PEND: begin
          err     = (f_low == '0);
          ipi_clr = f_low & ACT;
        end
        SEL_TMR_PEND: begin
          err     = (f_low == '0);
          tmr_clr = f_low & ACT;
        end
        default: begin
          err     = (f_low == '0);
          ipi_set = f_low & ACT;
        end
      endcase
    end
  end
endmodule

// File: rtl/intc_pend_vec.sv
module intc_pend_vec
  import intc_pkg::*;
#(
  parameter bit SET_FIRST = 1'b1,
  parameter bit WARN_EN   = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cpu_mask_t set_m,
  input  cpu_mask_t clr_m,
  output cpu_mask_t pend,
  output logic      warn
);
  cpu_mask_t pend_q, pend_d, seen;
  logic      upd_en;

  generate
    if (SET_FIRST) begin : g_set_then_clr
      assign pend_d = (pend_q | set_m) & ~clr_m;
      assign seen   = pend_q | set_m;
    end else begin : g_clr_then_set
      assign pend_d = (pend_q & ~clr_m) | set_m;
      assign seen   = pend_q;
    end
    if (WARN_EN) begin : g_warn
      assign warn = (|(set_m & pend_q)) | (|(clr_m & ~seen));
    end else begin : g_nowarn
      assign warn = 1'b0;
    end
  endgenerate

  assign upd_en = |{set_m, clr_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import intc_pkg::*;
#(
  parameter int N_ACTIVE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [1:0]        req_cpu,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        ipi_irq,
  output logic [3:0]        tmr_irq,
  output logic              warn_pulse,
  output logic              err_pulse
);
  localparam cpu_mask_t ACT = cpu_mask_t'((1 << N_ACTIVE) - 1);

  logic      rst_s1_q, rst_q_n;
  reg_sel_e  sel;
  cpu_mask_t ipi_set, ipi_clr, tmr_clr, tmr_set;
  cpu_mask_t ipi_pend, tmr_pend;
  logic      dec_err, ipi_warn, tmr_warn;
  logic      warn_d, err_d, warn_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q_n  <= rst_s1_q;
    end
  end

  assign sel     = reg_sel_e'(req_sel);
  assign tmr_set = tick ? ACT : '0;

  intc_cmd_decode #(.N_ACTIVE(N_ACTIVE)) u_dec (
    .valid   (req_valid),
    .write   (req_write),
    .sel     (sel),
    .wdata   (req_wdata),
    .ipi_set (ipi_set),
    .ipi_clr (ipi_clr),
    .tmr_clr (tmr_clr),
    .err     (dec_err)
  );

  intc_pend_vec #(.SET_FIRST(1'b1), .WARN_EN(1'b1)) u_ipi (
    .clk   (clk),
    .rst_n (rst_q_n),
    .set_m (ipi_set),
    .clr_m (ipi_clr),
    .pend  (ipi_pend),
    .warn  (ipi_warn)
  );

  intc_pend_vec #(.SET_FIRST(1'b0), .WARN_EN(1'b0)) u_tmr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .set_m (tmr_set),
    .clr_m (tmr_clr),
    .pend  (tmr_pend),
    .warn  (tmr_warn)
  );

  assign warn_d = ipi_warn | tmr_warn;
  assign err_d  = dec_err;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      warn_q <= warn_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_write) begin
      unique case (sel)
        SEL_CTRL: begin
          rd_data[IPICLR_LSB +: CPU_SLOTS] = ipi_pend;
          rd_data[TMRCLR_LSB +: CPU_SLOTS] = tmr_pend;
          rd_data[1:0]                     = req_cpu;
        end
        SEL_IPI_PEND: rd_data[0 +: CPU_SLOTS] = ipi_pend;
        SEL_TMR_PEND: rd_data[0 +: CPU_SLOTS] = tmr_pend;
        default:      rd_data = '0;
      endcase
    end
  end

  assign ipi_irq    = ipi_pend;
  assign tmr_irq    = tmr_pend;
  assign warn_pulse = warn_q;
  assign err_pulse  = err_q;
endmodule

// File: rtl/ipi_timer_intc_chk.sv
module ipi_timer_intc_chk #(
  parameter int N_ACTIVE = 4
) (
  input logic        clk,
  input logic        rst_q_n,
  input logic        tick,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_sel,
  input logic [63:0] req_wdata,
  input logic [3:0]  ipi_irq,
  input logic [3:0]  tmr_irq,
  input logic        warn_pulse,
  input logic        err_pulse
);
  localparam logic [3:0] ACT = 4'((1 << N_ACTIVE) - 1);

  assert_inactive_quiet_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((ipi_irq & ~ACT) == 4'd0) && ((tmr_irq & ~ACT) == 4'd0));

  assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick |=> ((tmr_irq & ACT) == ACT));

  assert_ctrl_err_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_write && req_sel == 2'd0 && req_wdata[15:4] == 12'd0 && !req_wdata[28])
      |=> err_pulse);

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_pulse |-> $past(req_valid && req_write));

  assert_warn_cause_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    warn_pulse |-> $past(req_valid && req_write));

  assert_ipi_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(req_valid && req_write) |=> $stable(ipi_irq));
endmodule

bind ipi_timer_intc ipi_timer_intc_chk #(.N_ACTIVE(N_ACTIVE)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .tick       (tick),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_sel    (req_sel),
  .req_wdata  (req_wdata),
  .ipi_irq    (ipi_irq),
  .tmr_irq    (tmr_irq),
  .warn_pulse (warn_pulse),
  .err_pulse  (err_pulse)
);

// File: tb/ipi_timer_intc_tb.sv
module ipi_timer_intc_tb;
  localparam int NACT = 3;
  localparam logic [3:0] ACT = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        req_valid, req_write;
  logic [1:0]  req_sel, req_cpu;
  logic [63:0] req_wdata;
  logic [63:0] rd_data;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        warn_pulse, err_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ipi_timer_intc #(.N_ACTIVE(NACT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_cpu(req_cpu), .req_wdata(req_wdata), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .warn_pulse(warn_pulse), .err_pulse(err_pulse)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // drive for one rising edge; on return, registered results are due
  task automatic op(input logic wr, input logic [1:0] sel, input logic [63:0] d, input logic tk);
    @(negedge clk);
    req_valid = wr; req_write = wr; req_sel = sel; req_wdata = d; tick = tk;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = '0; tick = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] cpu, output logic [63:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = sel; req_cpu = cpu;
    #1 v = rd_data;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [63:0] v;
    rst_n = 0; tick = 0; req_valid = 0; req_write = 0;
    req_sel = 0; req_cpu = 0; req_wdata = '0;
    repeat (3) @(posedge clk);
    check("R1 ipi in reset", 64'(ipi_irq), 64'h0);
    check("R1 flags in reset", 64'({warn_pulse, err_pulse}), 64'h0);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 ipi after release", 64'(ipi_irq), 64'h0);
    check("R1 tmr after release", 64'(tmr_irq), 64'h0);
    check("R1 flags after release", 64'({warn_pulse, err_pulse}), 64'h0);

    // R8 control read, each requester number
    for (int c = 0; c < 4; c++) begin
      rd(2'd0, 2'(c), v);
      check("R8 ctrl read idle", v, 64'(c));
    end

    // R6 accept-only write and malformed write
    op(1, 2'd0, 64'h1000_0000, 0);
    check("R6 accept-only err", 64'(err_pulse), 64'h0);
    check("R6 accept-only ipi", 64'(ipi_irq), 64'h0);
    op(1, 2'd0, 64'hFFFF_0000_0F00_000F, 0);
    check("R6 empty fields err", 64'(err_pulse), 64'h1);
    check("R6 empty fields ipi", 64'(ipi_irq), 64'h0);

    // R10 zero mask on dedicated registers
    for (int s = 1; s < 4; s++) begin
      op(1, 2'(s), 64'hF0, 0);
      check("R10 zero mask err", 64'(err_pulse), 64'h1);
      check("R10 zero mask ipi", 64'(ipi_irq), 64'h0);
    end

    // R11 inactive slot only
    op(1, 2'd3, 64'h8, 0);
    check("R11 inactive ipi", 64'(ipi_irq), 64'h0);
    check("R11 inactive flags", 64'({warn_pulse, err_pulse}), 64'h0);

    // R9 dedicated registers
    op(1, 2'd3, 64'h5, 0);
    check("R9 request reg sets", 64'(ipi_irq), 64'h5);
    rd(2'd1, 2'd0, v);
    check("R9 ipi pend read", v, 64'h5);
    rd(2'd3, 2'd0, v);
    check("R9 request reg reads zero", v, 64'h0);
    check("R9 read no effect", 64'(ipi_irq), 64'h5);
    op(1, 2'd1, 64'h1, 0);
    check("R9 ipi pend write clears", 64'(ipi_irq), 64'h4);
    op(1, 2'd1, 64'h1, 0);
    check("R5 retire not pending warn", 64'(warn_pulse), 64'h1);
    op(1, 2'd3, 64'h4, 0);
    check("R5 repost warn", 64'(warn_pulse), 64'h1);
    check("R5 repost state", 64'(ipi_irq), 64'h4);

    // R7 tick
    op(0, 2'd0, 64'h0, 1);
    check("R7 tick sets", 64'(tmr_irq), 64'(ACT));
    check("R7 tick no warn", 64'(warn_pulse), 64'h0);
    rd(2'd2, 2'd0, v);
    check("R9 tmr pend read", v, 64'(ACT));
    rd(2'd0, 2'd1, v);
    check("R8 ctrl read busy", v, 64'h0471);
    op(1, 2'd2, 64'h2, 0);
    check("R9 tmr pend write clears", 64'(tmr_irq), 64'h5);
    op(1, 2'd2, 64'h1, 1);
    check("R7 tick beats retire", 64'(tmr_irq), 64'(ACT));

    // R2 R3 R4 R5 R11 sweep: start state x request field x retire field
    for (int s = 0; s < 16; s++) begin
      for (int r = 0; r < 16; r++) begin
        for (int c = 0; c < 16; c++) begin
          logic [3:0] i0, rq, ci, i1;
          logic er, wn;
          op(1, 2'd1, 64'hF, 1);
          if (s != 0) op(1, 2'd3, 64'(s), 0);
          i0 = 4'(s) & ACT;
          rq = 4'(r) & ACT;
          ci = 4'(c) & ACT;
          er = (r == 0) && (c == 0);
          wn = !er && ((|(rq & i0)) || (|(ci & ~(i0 | rq))));
          i1 = er ? i0 : ((i0 | rq) & ~ci);
          op(1, 2'd0, {48'h0, 4'(r), 4'(c), 4'(c), 4'h0}, 0);
          check("R2 R4 sweep ipi", 64'(ipi_irq), 64'(i1));
          check("R3 sweep tmr", 64'(tmr_irq), 64'(er ? ACT : (ACT & ~ci)));
          check("R5 sweep warn", 64'(warn_pulse), 64'(wn));
          check("R6 sweep err", 64'(err_pulse), 64'(er));
        end
      end
    end

    done = 1;
    report();
  end
endmodule